// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block gathers the interrupt sources of a serial port controller and turns them into a single interrupt request and an 8-bit identification value. Its inputs are the line status flags, a receive-timeout pending flag, a transmit-empty pending flag, the receive FIFO fill count, a trigger-level select, the FIFO enable bit and the four modem-status change bits. The block holds the 4-bit interrupt enable register itself, which software writes through a strobe and a data byte.

Five sources compete under a fixed priority. The winning source's code goes to the low nibble of the identification value. The top two bits of that value show whether FIFO mode is on. The request line is registered and is high exactly when some source is reported. Reads of the identification and line status registers, and writes of the enable register, produce one-cycle strobes. The neighbouring blocks that own the pending flags use these strobes to clear or re-arm those flags.

The line status byte is decoded by position: bit 0 data ready, bit 1 overrun, bit 2 parity error, bit 3 framing error, bit 4 break, bit 5 holding register empty. Bits 6 and 7 are ignored.

Top module: `uart_irq_ident`

## Requirements
- R1: While reset is high, and on the cycle after it falls, `id_q` is 0x01, `irq` is 0, `en_q` is 0 and all three strobes are 0.
- R2: When several sources are active and enabled, the reported one is the highest in this order: line status, character timeout, receive data, transmit empty, modem status.
- R3: `id_q[3:0]` is 0x6 for line status, 0xC for timeout, 0x4 for receive data, 0x2 for transmit empty, 0x0 for modem status and 0x1 when no source is active; bits 5:4 are 0.
- R4: The line status source is active only when `en_q[2]` is 1 and at least one of `line_stat[4:1]` is 1. Data ready alone (bit 0) does not activate it.
- R5: The receive data source needs `en_q[0]` and `line_stat[0]`. With `fifo_en` high, it also needs `rx_count` to be at least the trigger level: 1, DEPTH/4, DEPTH/2 or DEPTH-2 for `trig_sel` 0 to 3 (1, 4, 8, 14 at DEPTH=16). With `fifo_en` low, the count is ignored.
- R6: The timeout source is active only when `rx_tmo_pend` is 1 and `en_q[0]` is 1.
- R7: `id_q[7:6]` is 2'b11 when `fifo_en` was high at the capturing edge and 2'b00 otherwise.
- R8: `irq` is 1 exactly when `id_q[3:0]` is not 0x1. Both outputs take on a new input value at the first rising edge after it is applied.
- R9: A cycle with `id_rd` high while `id_q[3:0]` is 0x2 gives a one-cycle `thre_pend_clr` pulse on the next cycle. A read that finds any other code gives no pulse.
- R10: A cycle with `en_wr` high stores `en_wdata[3:0]` into `en_q` at that edge. If `line_stat[5]` is 1 in that cycle, `thre_pend_set` pulses for one cycle after the edge.
- R11: A cycle with `stat_rd` high while `line_stat[1]` or `line_stat[4]` is 1 gives a one-cycle `lsr_err_clr` pulse on the next cycle. Parity or framing errors alone give no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register write data (low 4 bits kept) |
| id_rd | input | 1 | Identification register read strobe |
| stat_rd | input | 1 | Line status register read strobe |
| line_stat | input | 8 | Line status flags (bit map in the description) |
| rx_tmo_pend | input | 1 | Receive character timeout pending |
| thre_pend | input | 1 | Transmit holding empty pending |
| rx_count | input | CNT_W | Receive FIFO fill count |
| trig_sel | input | 2 | Receive trigger level select |
| fifo_en | input | 1 | FIFO mode enabled |
| msr_delta | input | 4 | Modem status change bits |
| en_q | output | 4 | Stored interrupt enable register |
| id_q | output | 8 | Interrupt identification value |
| irq | output | 1 | Interrupt request |
| thre_pend_clr | output | 1 | Clear the transmit-empty pending flag |
| thre_pend_set | output | 1 | Set the transmit-empty pending flag |
| lsr_err_clr | output | 1 | Clear the break and overrun flags |

## Verification
The properties assume that every input is steady across each clock cycle. They also assume the read and write strobes are single-cycle pulses whose effect depends only on the state sampled at that edge. Because source qualification uses the stored `en_q` and not the write data, the enable checks take a one-cycle lag after a write for granted. The bench applies every input change just after a rising edge and holds it for whole cycles. It waits two edges after an enable write before judging the identification value, and it raises each strobe for exactly one cycle.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC = 5;

  // line status bit positions decoded by this block
  localparam int LS_DR   = 0;
  localparam int LS_OE   = 1;
  localparam int LS_PE   = 2;
  localparam int LS_FE   = 3;
  localparam int LS_BI   = 4;
  localparam int LS_THRE = 5;

  typedef enum logic [3:0] {
    ID_MODEM   = 4'h0,
    ID_NONE    = 4'h1,
    ID_THRE    = 4'h2,
    ID_RXDATA  = 4'h4,
    ID_LINE    = 4'h6,
    ID_TIMEOUT = 4'hC
  } irq_id_e;

  // source index 0 is the highest priority
  function automatic irq_id_e src_id(int idx);
    case (idx)
      0:       return ID_LINE;
      1:       return ID_TIMEOUT;
      2:       return ID_RXDATA;
      3:       return ID_THRE;
      default: return ID_MODEM;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_trig.sv
module uart_irq_trig #(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [1:0]       sel,
  output logic [CNT_W-1:0] level
);
  localparam int LVL1 = 1;
  localparam int LVL2 = (DEPTH / 4 > 0) ? DEPTH / 4 : 1;
  localparam int LVL3 = (DEPTH / 2 > 0) ? DEPTH / 2 : 1;
  localparam int LVL4 = (DEPTH > 2) ? DEPTH - 2 : 1;

  always_comb begin
    case (sel)
      2'd0:    level = CNT_W'(LVL1);
      2'd1:    level = CNT_W'(LVL2);
      2'd2:    level = CNT_W'(LVL3);
      default: level = CNT_W'(LVL4);
    endcase
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [NSRC-1:0] req,
  output irq_id_e         id
);
  always_comb begin
    id = ID_NONE;
    // walk from lowest to highest so the highest active source wins
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) id = src_id(i);
    end
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_wr,
  input  logic [7:0]       en_wdata,
  input  logic             id_rd,
  input  logic             stat_rd,
  input  logic [7:0]       line_stat,
  input  logic             rx_tmo_pend,
  input  logic             thre_pend,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [1:0]       trig_sel,
  input  logic             fifo_en,
  input  logic [3:0]       msr_delta,
  output logic [3:0]       en_q,
  output logic [7:0]       id_q,
  output logic             irq,
  output logic             thre_pend_clr,
  output logic             thre_pend_set,
  output logic             lsr_err_clr
);
  logic [CNT_W-1:0] trig_level;
  logic [NSRC-1:0]  src_req;
  logic             level_ok;
  irq_id_e          cur_id;

  uart_irq_trig #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_trig (
    .sel   (trig_sel),
    .level (trig_level)
  );

  always_comb begin
    level_ok   = !fifo_en || (rx_count >= trig_level);
    src_req[0] = en_q[2] && (line_stat[LS_OE] || line_stat[LS_PE] ||
                             line_stat[LS_FE] || line_stat[LS_BI]);
    src_req[1] = en_q[0] && rx_tmo_pend;
    src_req[2] = en_q[0] && line_stat[LS_DR] && level_ok;
    src_req[3] = en_q[1] && thre_pend;
    src_req[4] = en_q[3] && (|msr_delta);
  end

  uart_irq_prio u_prio (
    .req (src_req),
    .id  (cur_id)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q          <= 4'h0;
      id_q          <= {4'h0, ID_NONE};
      irq           <= 1'b0;
      thre_pend_clr <= 1'b0;
      thre_pend_set <= 1'b0;
      lsr_err_clr   <= 1'b0;
    end else begin
      if (en_wr) en_q <= en_wdata[3:0];
      id_q          <= {{2{fifo_en}}, 2'b00, cur_id};
      irq           <= (cur_id != ID_NONE);
      thre_pend_clr <= id_rd && (id_q[3:0] == ID_THRE);
      thre_pend_set <= en_wr && line_stat[LS_THRE];
      lsr_err_clr   <= stat_rd && (line_stat[LS_OE] || line_stat[LS_BI]);
    end
  end
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic       clk,
  input logic       rst,
  input logic       en_wr,
  input logic [7:0] en_wdata,
  input logic       id_rd,
  input logic       stat_rd,
  input logic [7:0] line_stat,
  input logic       rx_tmo_pend,
  input logic       fifo_en,
  input logic [3:0] en_q,
  input logic [7:0] id_q,
  input logic       irq,
  input logic       thre_pend_clr,
  input logic       thre_pend_set,
  input logic       lsr_err_clr
);
  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (id_q == 8'h01 && !irq && en_q == 4'h0));

  // R3
  legal_code_chk: assert property (@(posedge clk) disable iff (rst)
    (id_q[3:0] inside {4'h0, 4'h1, 4'h2, 4'h4, 4'h6, 4'hC}) && id_q[5:4] == 2'b00);

  // R4
  line_first_chk: assert property (@(posedge clk) disable iff (rst)
    (en_q[2] && (|line_stat[4:1])) |=> id_q[3:0] == 4'h6);

  // R6
  tmo_masked_chk: assert property (@(posedge clk) disable iff (rst)
    !en_q[0] |=> (id_q[3:0] != 4'hC && id_q[3:0] != 4'h4));

  // R7
  fifo_bits_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_en |=> id_q[7:6] == 2'b11);

  // R8
  quiet_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (en_q == 4'h0 && !en_wr) |=> (!irq && id_q[3:0] == 4'h1));

  // R9
  thre_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (id_rd && id_q[3:0] == 4'h2) |=> thre_pend_clr);

  // R9
  thre_clr_none_chk: assert property (@(posedge clk) disable iff (rst)
    !id_rd |=> !thre_pend_clr);

  // R10
  en_store_chk: assert property (@(posedge clk) disable iff (rst)
    en_wr |=> en_q == $past(en_wdata[3:0]));

  // R10
  thre_set_chk: assert property (@(posedge clk) disable iff (rst)
    (en_wr && line_stat[5]) |=> thre_pend_set);

  // R11
  err_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && (line_stat[1] || line_stat[4])) |=> lsr_err_clr);

  // R11
  err_clr_none_chk: assert property (@(posedge clk) disable iff (rst)
    !stat_rd |=> !lsr_err_clr);
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .en_wr         (en_wr),
  .en_wdata      (en_wdata),
  .id_rd         (id_rd),
  .stat_rd       (stat_rd),
  .line_stat     (line_stat),
  .rx_tmo_pend   (rx_tmo_pend),
  .fifo_en       (fifo_en),
  .en_q          (en_q),
  .id_q          (id_q),
  .irq           (irq),
  .thre_pend_clr (thre_pend_clr),
  .thre_pend_set (thre_pend_set),
  .lsr_err_clr   (lsr_err_clr)
);

// File: tb/sim_uart_irq_ident.sv
`timescale 1ns/1ps
module sim_uart_irq_ident;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en_wr = 1'b0;
  logic [7:0]    en_wdata = 8'h00;
  logic          id_rd = 1'b0;
  logic          stat_rd = 1'b0;
  logic [7:0]    line_stat = 8'h00;
  logic          rx_tmo_pend = 1'b0;
  logic          thre_pend = 1'b0;
  logic [CW-1:0] rx_count = '0;
  logic [1:0]    trig_sel = 2'd0;
  logic          fifo_en = 1'b0;
  logic [3:0]    msr_delta = 4'h0;
  logic [3:0]    en_q;
  logic [7:0]    id_q;
  logic          irq;
  logic          thre_pend_clr, thre_pend_set, lsr_err_clr;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_irq_ident #(.FIFO_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .en_wr(en_wr), .en_wdata(en_wdata), .id_rd(id_rd),
    .stat_rd(stat_rd), .line_stat(line_stat), .rx_tmo_pend(rx_tmo_pend),
    .thre_pend(thre_pend), .rx_count(rx_count), .trig_sel(trig_sel),
    .fifo_en(fifo_en), .msr_delta(msr_delta), .en_q(en_q), .id_q(id_q),
    .irq(irq), .thre_pend_clr(thre_pend_clr), .thre_pend_set(thre_pend_set),
    .lsr_err_clr(lsr_err_clr)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_en(logic [7:0] v);
    en_wr = 1'b1; en_wdata = v;
    tick();
    en_wr = 1'b0;
    tick();
  endtask

  task automatic clear_inputs();
    line_stat = 8'h00; rx_tmo_pend = 1'b0; thre_pend = 1'b0;
    rx_count = '0; trig_sel = 2'd0; fifo_en = 1'b0; msr_delta = 4'h0;
    tick();
  endtask

  task automatic t_reset();
    check("R1 id", id_q, 8'h01);
    check("R1 irq", {7'h0, irq}, 8'h00);
    check("R1 en", {4'h0, en_q}, 8'h00);
    check("R1 strobes", {5'h0, thre_pend_clr, thre_pend_set, lsr_err_clr}, 8'h00);
  endtask

  task automatic t_en_write();
    line_stat = 8'h20;
    en_wr = 1'b1; en_wdata = 8'hFF;
    tick();
    en_wr = 1'b0;
    check("R10 low bits stored", {4'h0, en_q}, 8'h0F);
    check("R10 set pulse", {7'h0, thre_pend_set}, 8'h01);
    tick();
    check("R10 set pulse ends", {7'h0, thre_pend_set}, 8'h00);
    line_stat = 8'h00;
    en_wr = 1'b1; en_wdata = 8'hA5;
    tick();
    en_wr = 1'b0;
    check("R10 stored 5", {4'h0, en_q}, 8'h05);
    check("R10 no set when busy", {7'h0, thre_pend_set}, 8'h00);
    tick();
  endtask

  task automatic t_line();
    write_en(8'h04);
    line_stat = 8'h01;
    tick();
    check("R4 data ready alone", id_q, 8'h01);
    for (int b = 1; b <= 4; b++) begin
      line_stat = 8'h01 << b;
      tick();
      check("R4 error bit", id_q, 8'h06);
      check("R8 irq high", {7'h0, irq}, 8'h01);
    end
    write_en(8'h0B);
    check("R4 masked", id_q, 8'h01);
    check("R8 irq low", {7'h0, irq}, 8'h00);
    clear_inputs();
  endtask

  task automatic t_prio();
    write_en(8'h0F);
    line_stat = 8'h13; rx_tmo_pend = 1'b1; thre_pend = 1'b1; msr_delta = 4'h8;
    tick(); check("R2 line wins", id_q, 8'h06);
    line_stat = 8'h01;
    tick(); check("R3 timeout code", id_q, 8'h0C);
    rx_tmo_pend = 1'b0;
    tick(); check("R3 rx data code", id_q, 8'h04);
    line_stat = 8'h00;
    tick(); check("R3 thre code", id_q, 8'h02);
    thre_pend = 1'b0;
    tick(); check("R3 modem code", id_q, 8'h00);
    check("R8 irq for modem", {7'h0, irq}, 8'h01);
    msr_delta = 4'h0;
    tick(); check("R3 none code", id_q, 8'h01);
    clear_inputs();
  endtask

  task automatic t_timeout_mask();
    write_en(8'h0E);
    rx_tmo_pend = 1'b1;
    tick(); check("R6 timeout masked", id_q, 8'h01);
    thre_pend = 1'b1;
    tick(); check("R6 thre below masked timeout", id_q, 8'h02);
    write_en(8'h01);
    thre_pend = 1'b0;
    tick(); check("R6 timeout enabled", id_q, 8'h0C);
    clear_inputs();
  endtask

  task automatic t_fifo_level();
    write_en(8'h01);
    fifo_en = 1'b1; line_stat = 8'h01; trig_sel = 2'd1; rx_count = CW'(3);
    tick(); check("R5 below level 4", id_q, 8'hC1);
    rx_count = CW'(4);
    tick(); check("R5 at level 4", id_q, 8'hC4);
    trig_sel = 2'd2; rx_count = CW'(7);
    tick(); check("R5 below level 8", id_q, 8'hC1);
    trig_sel = 2'd3; rx_count = CW'(13);
    tick(); check("R5 below level 14", id_q, 8'hC1);
    rx_count = CW'(14);
    tick(); check("R5 at level 14", id_q, 8'hC4);
    trig_sel = 2'd0; rx_count = CW'(1);
    tick(); check("R5 at level 1", id_q, 8'hC4);
    fifo_en = 1'b0; rx_count = '0;
    tick(); check("R7 no fifo, count ignored", id_q, 8'h04);
    fifo_en = 1'b1; line_stat = 8'h00;
    tick(); check("R7 fifo bits idle", id_q, 8'hC1);
    clear_inputs();
  endtask

  task automatic t_latency();
    write_en(8'h08);
    check("R8 idle before", {7'h0, irq}, 8'h00);
    msr_delta = 4'h1;
    #1;
    check("R8 unchanged before edge", {7'h0, irq}, 8'h00);
    tick();
    check("R8 raised after one edge", {7'h0, irq}, 8'h01);
    msr_delta = 4'h0;
    tick();
    check("R8 lowered after one edge", {7'h0, irq}, 8'h00);
    clear_inputs();
  endtask

  task automatic t_id_read();
    write_en(8'h02);
    thre_pend = 1'b1;
    tick(); check("R9 thre reported", id_q, 8'h02);
    id_rd = 1'b1;
    tick(); id_rd = 1'b0;
    check("R9 clear pulse", {7'h0, thre_pend_clr}, 8'h01);
    tick(); check("R9 pulse one cycle", {7'h0, thre_pend_clr}, 8'h00);
    write_en(8'h03);
    line_stat = 8'h01;
    tick(); check("R9 rx data reported", id_q, 8'h04);
    id_rd = 1'b1;
    tick(); id_rd = 1'b0;
    check("R9 no pulse for other code", {7'h0, thre_pend_clr}, 8'h00);
    clear_inputs();
  endtask

  task automatic t_stat_read();
    line_stat = 8'h10; stat_rd = 1'b1;
    tick(); stat_rd = 1'b0;
    check("R11 break clears", {7'h0, lsr_err_clr}, 8'h01);
    tick(); check("R11 pulse one cycle", {7'h0, lsr_err_clr}, 8'h00);
    line_stat = 8'h02; stat_rd = 1'b1;
    tick(); stat_rd = 1'b0;
    check("R11 overrun clears", {7'h0, lsr_err_clr}, 8'h01);
    line_stat = 8'h0C; stat_rd = 1'b1;
    tick(); stat_rd = 1'b0;
    check("R11 parity framing no pulse", {7'h0, lsr_err_clr}, 8'h00);
    clear_inputs();
  endtask

  initial begin
    tick(); tick(); tick();
    t_reset();
    rst = 1'b0;
    t_reset();
    tick();
    t_en_write();
    t_line();
    t_prio();
    t_timeout_mask();
    t_fifo_level();
    t_latency();
    t_id_read();
    t_stat_read();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule